// File: doc/BRIEF.md
# Lane-Ordered FIFO Read Guard

This block sits between a bus slave that can read one, two, three or four bytes per access and four byte-wide first-word-fall-through FIFOs, one FIFO per byte lane. Byte address `a` in the FIFO segment belongs to lane `a mod 4`. The block keeps a separate word position for each lane. An access is accepted only if every byte it touches is the next unread byte of that byte's lane. The bytes of a segment can therefore be read with any mix of widths, as long as the reads move through the bytes in ascending order.

An accepted access pops the lanes it touches in the cycle of the request and returns their head bytes one cycle later with an acknowledge. Three kinds of access are refused with a bus error and change nothing: an access out of order, an access whose lane enables do not match its size and start lane, and a block transfer that is not an aligned 32-bit read. Every access attempt also produces one-cycle event pulses that classify it, for use by the status logic outside the block. A retransmit command or a clear command returns every lane to the lowest address of the segment.

Top module: `lanefifo_rd_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_ack`, `rsp_berr`, `rsp_data`, `fifo_pop` and all event outputs are zero. After reset every lane expects word 0, so a 4-byte read at offset 0 is accepted.
- R2: Byte lane n of `rsp_data` (bits 8n+7..8n) holds the lane-n FIFO head of an accepted access that touches lane n. Lanes the access does not touch read as zero.
- R3: An access is accepted when it is well formed (R6), is a legal block attempt (R7), and for every set bit n of `acc_lanes` the word position of lane n equals `acc_addr[AW-1:2]`. Exactly one cycle after the request, `rsp_ack` is 1.
- R4: In the request cycle of an accepted access, `fifo_pop` equals `acc_lanes`, and each touched lane's position then increases by one. A 4-byte access advances four lanes, a 2-byte access two lanes, a 1-byte access one lane. No pop happens in any other case.
- R5: A request that is not accepted gives `rsp_berr`=1 one cycle later, no acknowledge, no pop and no change of position. For example, after a 1-byte read at offset 0, offset 5 is refused until lane 1 has been read at offset 1.
- R6: `acc_size` encodes the byte count minus one (0 = one byte, 3 = four bytes). An access is well formed only if `acc_lanes` has exactly the bits from `acc_addr[1:0]` to `acc_addr[1:0]+acc_size` set, and that range does not go past lane 3. Any other access is refused.
- R7: When `acc_blk`=1, the access is legal only with `acc_size`=3 and `acc_addr[1:0]`=0. Any other block attempt is refused and pulses `ev_ublk`.
- R8: Each request pulses exactly one of `ev_one`, `ev_two`, `ev_three`, `ev_four` one cycle later, chosen by `acc_size` (0..3), whether the access is accepted or not.
- R9: A request with `acc_size`>0 whose start lane k=`acc_addr[1:0]` is 1, 2 or 3 pulses `ev_unal[k-1]` one cycle later. All other requests leave `ev_unal` zero.
- R10: `ev_blk` pulses one cycle after every block attempt. `ev_berr` pulses together with every bus error.
- R11: `cmd_retx` or `cmd_clr` sets every lane back to word 0. A request in the same cycle is checked against the old positions, and the reset of the positions takes priority over the request's advance.
- R12: A read from a lane whose FIFO is empty is still acknowledged and advances that lane. Its data byte is undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Read access valid this cycle |
| acc_addr | input | AW | Byte offset within the FIFO segment |
| acc_lanes | input | 4 | Byte lanes touched by the access |
| acc_size | input | 2 | Byte count minus one |
| acc_blk | input | 1 | Access is part of a block transfer |
| cmd_retx | input | 1 | Retransmit: rewind all lanes |
| cmd_clr | input | 1 | Clear: rewind all lanes |
| fifo_q | input | 32 | Head bytes of the four lane FIFOs |
| fifo_pop | output | 4 | Per-lane pop, same cycle as the request |
| rsp_data | output | 32 | Read data, one cycle after the request |
| rsp_ack | output | 1 | Access accepted |
| rsp_berr | output | 1 | Access refused |
| ev_one | output | 1 | Single-byte attempt |
| ev_two | output | 1 | Double-byte attempt |
| ev_three | output | 1 | Triple-byte attempt |
| ev_four | output | 1 | Quad-byte attempt |
| ev_unal | output | 3 | Multi-byte attempt starting at lane 1, 2 or 3 |
| ev_blk | output | 1 | Block transfer attempt |
| ev_ublk | output | 1 | Block transfer attempt that is not aligned |
| ev_berr | output | 1 | Bus error issued |

## Verification
The bench follows the sequence of single-byte reads that interleave lanes: offsets 0 and 3, then 7 is legal while 5 is not. A design that kept one shared pointer, instead of one pointer per lane, would refuse the read at 7 or accept the read at 5. Several cases check that a refused access does not advance anything. These are a repeated 4-byte read at offset 0, lane masks that do not match the size or start lane, and an unaligned block attempt. A design that advanced on refusal would then refuse the legal read that follows. Retransmit asserted together with a legal read checks the priority between rewind and advance. A read from empty FIFOs checks that emptiness is not treated as an error.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_ONE   = 2'd0,
    SZ_TWO   = 2'd1,
    SZ_THREE = 2'd2,
    SZ_FOUR  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic       one;
    logic       two;
    logic       three;
    logic       four;
    logic [2:0] unal;
    logic       blk;
    logic       ublk;
    logic       berr;
  } acc_events_t;

  // Lanes that an access of the given size starting at lane `start` must enable.
  function automatic logic [LANES-1:0] span_mask(input logic [1:0] start, input logic [1:0] size);
    logic [7:0] wide;
    wide = (8'd1 << ({1'b0, size} + 3'd1)) - 8'd1;
    wide = wide << start;
    return wide[LANES-1:0];
  endfunction

  // True when the span stays inside the four lanes of one word.
  function automatic logic span_fits(input logic [1:0] start, input logic [1:0] size);
    return ({1'b0, start} + {1'b0, size}) <= 3'd3;
  endfunction

  // Block transfers are legal only as aligned quad-byte reads.
  function automatic logic blk_legal(input logic [1:0] start, input logic [1:0] size);
    return (acc_size_e'(size) == SZ_FOUR) && (start == 2'd0);
  endfunction
endpackage

// File: rtl/lfg_lane_ptrs.sv
module lfg_lane_ptrs
  import lfg_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          adv,
  input  logic                      restart,
  output logic [LANES-1:0][PW-1:0]  pos
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PW-1:0] pos_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (restart) pos_q <= '0;
      else if (adv[g])  pos_q <= pos_q + 1'b1;
    end
    assign pos[g] = pos_q;
  end
endmodule

// File: rtl/lfg_access_check.sv
module lfg_access_check
  import lfg_pkg::*;
#(
  parameter int AW = 14,
  parameter int PW = AW - 2
) (
  input  logic                      req,
  input  logic [AW-1:0]             addr,
  input  logic [LANES-1:0]          lanes,
  input  logic [1:0]                size,
  input  logic                      blk,
  input  logic [LANES-1:0][PW-1:0]  pos,
  output logic                      accept,
  output logic                      reject,
  output logic                      bad_shape,
  output logic                      bad_order,
  output logic                      bad_blk
);
  logic [1:0]       start;
  logic [PW-1:0]    word;
  logic [LANES-1:0] lane_ok;

  assign start = addr[1:0];
  assign word  = addr[AW-1:2];

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign lane_ok[g] = !lanes[g] || (pos[g] == word);
  end

  always_comb begin
    bad_shape = !span_fits(start, size) || (lanes != span_mask(start, size));
    bad_order = !(&lane_ok);
    bad_blk   = blk && !blk_legal(start, size);
    accept    = req && !bad_shape && !bad_order && !bad_blk;
    reject    = req && !accept;
  end
endmodule

// File: rtl/lfg_event_gen.sv
module lfg_event_gen
  import lfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  size,
  input  logic [1:0]  start,
  input  logic        blk,
  input  logic        bad_blk,
  input  logic        reject,
  output acc_events_t ev
);
  acc_events_t nxt;

  for (genvar k = 1; k < LANES; k++) begin : g_unal
    assign nxt.unal[k-1] = req && (size != 2'd0) && (start == 2'(k));
  end

  assign nxt.one   = req && (acc_size_e'(size) == SZ_ONE);
  assign nxt.two   = req && (acc_size_e'(size) == SZ_TWO);
  assign nxt.three = req && (acc_size_e'(size) == SZ_THREE);
  assign nxt.four  = req && (acc_size_e'(size) == SZ_FOUR);
  assign nxt.blk   = req && blk;
  assign nxt.ublk  = req && bad_blk;
  assign nxt.berr  = reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev <= '0;
    else        ev <= nxt;
  end
endmodule

// File: rtl/lanefifo_rd_guard.sv
module lanefifo_rd_guard
  import lfg_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_req,
  input  logic [AW-1:0]            acc_addr,
  input  logic [3:0]               acc_lanes,
  input  logic [1:0]               acc_size,
  input  logic                     acc_blk,
  input  logic                     cmd_retx,
  input  logic                     cmd_clr,
  input  logic [31:0]              fifo_q,
  output logic [3:0]               fifo_pop,
  output logic [31:0]              rsp_data,
  output logic                     rsp_ack,
  output logic                     rsp_berr,
  output logic                     ev_one,
  output logic                     ev_two,
  output logic                     ev_three,
  output logic                     ev_four,
  output logic [2:0]               ev_unal,
  output logic                     ev_blk,
  output logic                     ev_ublk,
  output logic                     ev_berr
);
  localparam int PW = AW - 2;

  logic                      accept;
  logic                      reject;
  logic                      bad_shape;
  logic                      bad_order;
  logic                      bad_blk;
  logic                      restart;
  logic [LANES-1:0]          adv;
  logic [LANES-1:0][PW-1:0]  pos;
  acc_events_t               ev;

  assign restart = cmd_retx || cmd_clr;
  assign adv     = accept ? acc_lanes : '0;

  lfg_lane_ptrs #(.PW(PW)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .restart (restart),
    .pos     (pos)
  );

  lfg_access_check #(.AW(AW), .PW(PW)) u_check (
    .req       (acc_req),
    .addr      (acc_addr),
    .lanes     (acc_lanes),
    .size      (acc_size),
    .blk       (acc_blk),
    .pos       (pos),
    .accept    (accept),
    .reject    (reject),
    .bad_shape (bad_shape),
    .bad_order (bad_order),
    .bad_blk   (bad_blk)
  );

  lfg_event_gen u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (acc_req),
    .size    (acc_size),
    .start   (acc_addr[1:0]),
    .blk     (acc_blk),
    .bad_blk (bad_blk),
    .reject  (reject),
    .ev      (ev)
  );

  assign fifo_pop = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
      rsp_ack  <= 1'b0;
      rsp_berr <= 1'b0;
    end else begin
      for (int l = 0; l < LANES; l++)
        rsp_data[l*BYTE_W +: BYTE_W] <= adv[l] ? fifo_q[l*BYTE_W +: BYTE_W] : '0;
      rsp_ack  <= accept;
      rsp_berr <= reject;
    end
  end

  assign ev_one   = ev.one;
  assign ev_two   = ev.two;
  assign ev_three = ev.three;
  assign ev_four  = ev.four;
  assign ev_unal  = ev.unal;
  assign ev_blk   = ev.blk;
  assign ev_ublk  = ev.ublk;
  assign ev_berr  = ev.berr;
endmodule

// File: rtl/lfg_guard_chk.sv
module lfg_guard_chk #(
  parameter int PW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic [3:0]        acc_lanes,
  input logic [3:0]        fifo_pop,
  input logic              rsp_ack,
  input logic              rsp_berr,
  input logic              ev_one,
  input logic              ev_two,
  input logic              ev_three,
  input logic              ev_four,
  input logic              ev_ublk,
  input logic              ev_berr,
  input logic              reject,
  input logic              restart,
  input logic [4*PW-1:0]   pos_all
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> (rsp_ack ^ rsp_berr)); // R3
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> (!rsp_ack && !rsp_berr)); // R3
  AST_POP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop != 4'b0) |-> (acc_req && ((fifo_pop & ~acc_lanes) == 4'b0))); // R4
  AST_REJECT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (fifo_pop == 4'b0)); // R5
  AST_REJECT_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !restart) |=> $stable(pos_all)); // R5
  AST_UBLK_IS_BERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ublk |-> rsp_berr); // R7
  AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_one, ev_two, ev_three, ev_four})); // R8
  AST_BERR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_berr == rsp_berr); // R10
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pos_all == '0)); // R11
endmodule

bind lanefifo_rd_guard lfg_guard_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_req   (acc_req),
  .acc_lanes (acc_lanes),
  .fifo_pop  (fifo_pop),
  .rsp_ack   (rsp_ack),
  .rsp_berr  (rsp_berr),
  .ev_one    (ev_one),
  .ev_two    (ev_two),
  .ev_three  (ev_three),
  .ev_four   (ev_four),
  .ev_ublk   (ev_ublk),
  .ev_berr   (ev_berr),
  .reject    (reject),
  .restart   (restart),
  .pos_all   (pos)
);

// File: tb/lanefifo_rd_guard_tb.sv
module lanefifo_rd_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0;
  logic [13:0] acc_addr = '0;
  logic [3:0]  acc_lanes = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_blk = 1'b0;
  logic        cmd_retx = 1'b0;
  logic        cmd_clr = 1'b0;
  logic [31:0] fifo_q = '0;
  logic [3:0]  fifo_pop;
  logic [31:0] rsp_data;
  logic        rsp_ack, rsp_berr;
  logic        ev_one, ev_two, ev_three, ev_four;
  logic [2:0]  ev_unal;
  logic        ev_blk, ev_ublk, ev_berr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pos[4];
  logic [7:0] q[4][$];

  always #10 clk = ~clk;

  lanefifo_rd_guard u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
    .acc_lanes(acc_lanes), .acc_size(acc_size), .acc_blk(acc_blk),
    .cmd_retx(cmd_retx), .cmd_clr(cmd_clr), .fifo_q(fifo_q),
    .fifo_pop(fifo_pop), .rsp_data(rsp_data), .rsp_ack(rsp_ack),
    .rsp_berr(rsp_berr), .ev_one(ev_one), .ev_two(ev_two),
    .ev_three(ev_three), .ev_four(ev_four), .ev_unal(ev_unal),
    .ev_blk(ev_blk), .ev_ublk(ev_ublk), .ev_berr(ev_berr)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock of stimulus plus a full comparison against the reference model.
  task automatic step(input logic r, input int a, input logic [3:0] ln, input int sz,
                      input logic b, input logic rt, input logic cl);
    int st, wd;
    logic [3:0] want;
    logic shape, order, bok, acc;
    logic [31:0] ed, care;
    logic [2:0] eu;
    for (int l = 0; l < 4; l++) fifo_q[l*8 +: 8] = (q[l].size() > 0) ? q[l][0] : 8'hEE;
    acc_req = r; acc_addr = a[13:0]; acc_lanes = ln; acc_size = sz[1:0];
    acc_blk = b; cmd_retx = rt; cmd_clr = cl;
    st = a % 4; wd = a / 4; want = '0; shape = 1;
    for (int i = 0; i <= sz; i++) begin
      if (st + i > 3) shape = 0;
      else want[st + i] = 1'b1;
    end
    if (want != ln) shape = 0;
    order = 1;
    for (int l = 0; l < 4; l++) if (ln[l] && pos[l] != wd) order = 0;
    bok = !b || (sz == 3 && st == 0);
    acc = r && shape && order && bok;
    ed = '0; care = '1;
    for (int l = 0; l < 4; l++)
      if (acc && ln[l]) begin
        if (q[l].size() > 0) ed[l*8 +: 8] = q[l][0];
        else care[l*8 +: 8] = 8'h00;
      end
    eu = '0;
    if (r && sz > 0 && st > 0) eu[st-1] = 1'b1;
    #1;
    chk(fifo_pop == (acc ? ln : 4'b0), "R4", {28'b0, fifo_pop}, {28'b0, acc ? ln : 4'b0});
    @(negedge clk);
    chk(rsp_ack == acc, "R3", {31'b0, rsp_ack}, {31'b0, acc});
    chk(rsp_berr == (r && !acc), "R5", {31'b0, rsp_berr}, {31'b0, r && !acc});
    chk((rsp_data & care) == ed, "R2", rsp_data & care, ed);
    chk({ev_four, ev_three, ev_two, ev_one} == (r ? 4'(1 << sz) : 4'b0), "R8",
        {28'b0, ev_four, ev_three, ev_two, ev_one}, {28'b0, r ? 4'(1 << sz) : 4'b0});
    chk(ev_unal == eu, "R9", {29'b0, ev_unal}, {29'b0, eu});
    chk({ev_blk, ev_ublk} == {r && b, r && b && !bok}, "R7",
        {30'b0, ev_blk, ev_ublk}, {30'b0, r && b, r && b && !bok});
    chk(ev_berr == (r && !acc), "R10", {31'b0, ev_berr}, {31'b0, r && !acc});
    for (int l = 0; l < 4; l++)
      if (acc && ln[l]) begin
        if (q[l].size() > 0) void'(q[l].pop_front());
        pos[l]++;
      end
    if (rt || cl) for (int l = 0; l < 4; l++) pos[l] = 0;
  endtask

  task automatic rd(input int a, input logic [3:0] ln, input int sz);
    step(1'b1, a, ln, sz, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 0, 4'b0, 0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 4; l++) begin
      pos[l] = 0;
      for (int k = 0; k < 12; k++) q[l].push_back(8'(l * 64 + k + 1));
    end
    repeat (3) @(negedge clk);
    chk({rsp_ack, rsp_berr, fifo_pop, ev_berr, ev_one, ev_four} == '0, "R1",
        {23'b0, rsp_ack, rsp_berr, fifo_pop, ev_berr, ev_one, ev_four}, 32'b0);
    rst_n = 1'b1;
    idle();
    chk(rsp_data == 32'b0, "R1", rsp_data, 32'b0);
    // R1 / R3: quad at 0, repeat is out of order, then quad at 4
    rd(0, 4'b1111, 3);
    chk(rsp_ack, "R1", {31'b0, rsp_ack}, 32'd1);
    rd(0, 4'b1111, 3);
    rd(4, 4'b1111, 3);
    // R11: retransmit, then interleaved single bytes
    step(1'b0, 0, 4'b0, 0, 1'b0, 1'b1, 1'b0);
    rd(0, 4'b0001, 0);
    rd(3, 4'b1000, 0);
    rd(7, 4'b1000, 0);
    chk(rsp_ack, "R5", {31'b0, rsp_ack}, 32'd1);
    rd(5, 4'b0010, 0);
    chk(rsp_berr, "R5", {31'b0, rsp_berr}, 32'd1);
    rd(1, 4'b0010, 0);
    rd(2, 4'b0100, 0);
    rd(4, 4'b0001, 0);
    rd(5, 4'b0010, 0);
    rd(6, 4'b0100, 0);
    // unaligned doubles and triples
    rd(9, 4'b0110, 1);
    rd(8, 4'b0001, 0);
    rd(11, 4'b1000, 0);
    rd(13, 4'b1110, 2);
    rd(12, 4'b0001, 0);
    rd(16, 4'b0011, 1);
    rd(18, 4'b1100, 1);
    // R6: malformed accesses
    rd(20, 4'b0101, 1);
    chk(rsp_berr, "R6", {31'b0, rsp_berr}, 32'd1);
    rd(21, 4'b0011, 1);
    chk(rsp_berr, "R6", {31'b0, rsp_berr}, 32'd1);
    rd(22, 4'b1100, 2);
    chk(rsp_berr, "R6", {31'b0, rsp_berr}, 32'd1);
    rd(20, 4'b1111, 3);
    // R7: block transfers
    step(1'b1, 24, 4'b1111, 3, 1'b1, 1'b0, 1'b0);
    step(1'b1, 28, 4'b0011, 1, 1'b1, 1'b0, 1'b0);
    chk(ev_ublk && rsp_berr, "R7", {30'b0, ev_ublk, rsp_berr}, 32'd3);
    step(1'b1, 28, 4'b1111, 3, 1'b1, 1'b0, 1'b0);
    // R11: clear, then retransmit together with a legal read
    step(1'b0, 0, 4'b0, 0, 1'b0, 1'b0, 1'b1);
    rd(0, 4'b1111, 3);
    chk(rsp_ack, "R11", {31'b0, rsp_ack}, 32'd1);
    step(1'b1, 4, 4'b1111, 3, 1'b0, 1'b1, 1'b0);
    rd(0, 4'b1111, 3);
    chk(rsp_ack, "R11", {31'b0, rsp_ack}, 32'd1);
    // R12: empty FIFOs do not cause an error
    for (int l = 0; l < 4; l++) q[l].delete();
    rd(4, 4'b1111, 3);
    chk(rsp_ack && !rsp_berr, "R12", {30'b0, rsp_ack, rsp_berr}, 32'd2);
    rd(8, 4'b0001, 0);
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule